// File: doc/BRIEF.md
# Dual-Pattern Serial Sequence Detector

This block watches a serial bit stream that arrives one bit per rising clock edge. It reports a hit whenever the four most recently sampled bits form either of two 4-bit target words. Both targets are fixed when the block is elaborated. A pattern is read oldest bit first: bit 3, the leftmost bit, is the earliest bit to arrive.

The block is a Moore machine, so the hit flag comes only from the state register and never from the serial input directly. Each state holds the longest tail of the received stream that is also a leading part of either target. A completed match therefore keeps its own trailing bits, and those bits count toward the next match of either target. This covers overlapping occurrences and tails that the two targets share.

When both parameters hold the same word, the block acts as a single-pattern detector with the same ports. Reset is asserted asynchronously and active-low, and it is released through a two-stage synchronizer.

Top module: `seqdet_dual`

## Requirements
- R1: `found_o` changes only at a rising clock edge or on reset assertion; a change of `sd_i` between edges leaves `found_o` unchanged.
- R2: `found_o` is high in the cycle after the edge that samples the fourth bit of a window equal to `PAT_A` or `PAT_B`. Bit 3 of a pattern is the oldest bit of the window and bit 0 is the newest.
- R3: Matches may overlap. With `PAT_A`=0110 and `PAT_B`=1110, the stream 0110110 gives two hits and 1110110 gives two hits, because the trailing bits of each completed match count toward the next match of either pattern.
- R4: `rst_n_i` releases through two synchronizer stages, so the first bit is captured on the third rising edge after `rst_n_i` rises. `found_o` stays low until four bits have been captured.
- R5: `found_o` is low in every cycle whose last four captured bits match neither pattern.
- R6: When `PAT_A` equals `PAT_B`, the block flags exactly the windows equal to that single word.
- R7: `found_o` goes low as soon as `rst_n_i` goes low, with no clock edge needed, and it stays low while reset is held.
- R8: `found_o` stays high on consecutive cycles when consecutive windows match. With `PAT_A`=0101 and `PAT_B`=1010, an alternating stream holds it high on every cycle after the fourth captured bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; `sd_i` is sampled on the rising edge |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously |
| sd_i | input | 1 | Serial data bit |
| found_o | output | 1 | High while the last four captured bits equal either pattern |

## Verification
Two events can fall in the same cycle. One pattern can complete its match while its trailing bits are already building the next match of the other pattern, and an asynchronous reset can arrive while `found_o` is high. The bench provokes the first with streams such as 0110110 and 1110110, whose match tails are shared between the two patterns, and then feeds a long pseudo-random stream. It provokes the second by pulling reset low during a hit cycle. In every cycle it compares the flag with a queue that holds the captured bits. After a reset it checks that the flag drops without a clock and that the queue and the machine restart together.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;
  // Pattern length in bits; the detector is built around this width.
  localparam int SEQ_W = 4;
  // Width needed to count a matched-prefix length from 0 to SEQ_W.
  localparam int LEN_W = $clog2(SEQ_W + 1);

  // Matched-tail state: length of the longest received tail that is a
  // leading part of either pattern, plus the newest bits of that tail.
  // A full-length tail is a found state; its oldest bit is not needed.
  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic [SEQ_W-2:0] bits;
  } sfx_t;
endpackage

// File: rtl/seqdet_rst_sync.sv
module seqdet_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) pipe_q <= '0;
    else          pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = pipe_q[STAGES-1];
endmodule

// File: rtl/seqdet_next_state.sv
module seqdet_next_state
  import seqdet_pkg::*;
#(
  parameter logic [SEQ_W-1:0] PAT_A = 4'b0110,
  parameter logic [SEQ_W-1:0] PAT_B = 4'b1110
) (
  input  sfx_t cur_i,
  input  logic sd_i,
  output sfx_t nxt_o
);
  // Current tail extended by the incoming bit, newest bit at position 0.
  logic [SEQ_W-1:0] ext;
  logic [SEQ_W:0]   fits;
  logic [LEN_W-1:0] best_len;
  logic [SEQ_W-2:0] keep;

  assign ext     = {cur_i.bits, sd_i};
  assign fits[0] = 1'b1;

  // One comparator pair per candidate tail length.
  for (genvar k = 1; k <= SEQ_W; k++) begin : g_len
    logic reach;
    logic hit_a;
    logic hit_b;
    assign reach   = (int'(cur_i.len) >= k - 1);
    assign hit_a   = (ext[k-1:0] == PAT_A[SEQ_W-1 -: k]);
    assign hit_b   = (ext[k-1:0] == PAT_B[SEQ_W-1 -: k]);
    assign fits[k] = reach && (hit_a || hit_b);
  end

  // The longest fitting tail wins.
  always_comb begin
    best_len = '0;
    for (int k = 1; k <= SEQ_W; k++) begin
      if (fits[k]) best_len = LEN_W'(k);
    end
    for (int i = 0; i < SEQ_W - 1; i++) begin
      keep[i] = (i < int'(best_len));
    end
    nxt_o.len  = best_len;
    nxt_o.bits = ext[SEQ_W-2:0] & keep;
  end
endmodule

// File: rtl/seqdet_state_reg.sv
module seqdet_state_reg
  import seqdet_pkg::*;
(
  input  logic clk_i,
  input  logic rst_n_i,
  input  sfx_t nxt_i,
  output sfx_t cur_o
);
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) cur_o <= '0;
    else          cur_o <= nxt_i;
  end

  // R3: the tracked tail never grows past one full pattern.
  p_tail_bounded_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    int'(cur_o.len) <= SEQ_W);
endmodule

// File: rtl/seqdet_dual.sv
module seqdet_dual
  import seqdet_pkg::*;
#(
  parameter logic [SEQ_W-1:0] PAT_A      = 4'b0110,
  parameter logic [SEQ_W-1:0] PAT_B      = 4'b1110,
  parameter int               RST_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic sd_i,
  output logic found_o
);
  logic rst_sync_n;
  sfx_t cur_st;
  sfx_t nxt_st;

  seqdet_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .rst_n_o (rst_sync_n)
  );

  seqdet_next_state #(.PAT_A(PAT_A), .PAT_B(PAT_B)) u_next (
    .cur_i (cur_st),
    .sd_i  (sd_i),
    .nxt_o (nxt_st)
  );

  seqdet_state_reg u_state (
    .clk_i   (clk_i),
    .rst_n_i (rst_sync_n),
    .nxt_i   (nxt_st),
    .cur_o   (cur_st)
  );

  // Moore output: only the found states raise the flag.
  assign found_o = (cur_st.len == LEN_W'(SEQ_W));

  // Saturating count of captured bits since reset, for the checks below.
  logic [LEN_W-1:0] seen_q;
  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n)                   seen_q <= '0;
    else if (seen_q != LEN_W'(SEQ_W))  seen_q <= seen_q + 1'b1;
  end

  // R4: quiet until a full window has been captured.
  p_quiet_after_reset_r4: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (seen_q != LEN_W'(SEQ_W)) |-> !found_o);

  // R2: a raised flag is backed by a matching window of captured bits.
  p_hit_backed_r2: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    found_o |->
      ({$past(sd_i, 4), $past(sd_i, 3), $past(sd_i, 2), $past(sd_i, 1)} == PAT_A) ||
      ({$past(sd_i, 4), $past(sd_i, 3), $past(sd_i, 2), $past(sd_i, 1)} == PAT_B));

  // R5: a full window matching neither pattern keeps the flag low.
  p_miss_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    ((seen_q == LEN_W'(SEQ_W)) &&
     ({$past(sd_i, 4), $past(sd_i, 3), $past(sd_i, 2), $past(sd_i, 1)} != PAT_A) &&
     ({$past(sd_i, 4), $past(sd_i, 3), $past(sd_i, 2), $past(sd_i, 1)} != PAT_B))
    |-> !found_o);

  // R7: while the internal reset is held the flag is low.
  p_reset_clears_r7: assert property (@(posedge clk_i)
    !rst_sync_n |-> !found_o);
endmodule

// File: tb/seqdet_dual_tb.sv
`timescale 1ns/1ps
module seqdet_dual_tb_top;
  localparam logic [3:0] M_A = 4'b0110, M_B = 4'b1110;
  localparam logic [3:0] E_P = 4'b0010;
  localparam logic [3:0] L_A = 4'b0101, L_B = 4'b1010;

  logic clk = 1'b0;
  logic rst_n;
  logic sd;
  logic found_m, found_e, found_l;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  bit   hist[$];
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;  // 250 MHz

  seqdet_dual #(.PAT_A(M_A), .PAT_B(M_B)) dut_i (
    .clk_i(clk), .rst_n_i(rst_n), .sd_i(sd), .found_o(found_m));
  seqdet_dual #(.PAT_A(E_P), .PAT_B(E_P)) dut_eq_i (
    .clk_i(clk), .rst_n_i(rst_n), .sd_i(sd), .found_o(found_e));
  seqdet_dual #(.PAT_A(L_A), .PAT_B(L_B)) dut_alt_i (
    .clk_i(clk), .rst_n_i(rst_n), .sd_i(sd), .found_o(found_l));

  function automatic bit ref_hit(logic [3:0] a, logic [3:0] b);
    logic [3:0] w;
    if (hist.size() < 4) return 1'b0;
    w = {hist[hist.size()-4], hist[hist.size()-3], hist[hist.size()-2], hist[hist.size()-1]};
    return (w == a) || (w == b);
  endfunction

  task automatic check(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: found=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  task automatic check_all(string mtag);
    bit em, ee, el;
    string tm;
    em = ref_hit(M_A, M_B);
    ee = ref_hit(E_P, E_P);
    el = ref_hit(L_A, L_B);
    if (mtag != "") tm = mtag;
    else if (hist.size() < 4) tm = "R4";
    else tm = em ? "R2" : "R5";
    check(tm, found_m, em);
    check("R6", found_e, ee);
    check("R8", found_l, el);
  endtask

  // One cycle: check at the falling edge, wiggle sd (R1), then drive b.
  task automatic step(bit b, bit push, string mtag = "");
    logic held;
    @(negedge clk);
    check_all(mtag);
    held = found_m;
    sd = ~b;
    #0.5;
    check("R1", found_m, held);
    sd = b;
    if (push) hist.push_back(b);
  endtask

  task automatic do_reset(bit pre_check);
    @(negedge clk);
    if (pre_check) check_all("");
    rst_n = 1'b0;
    #0.5;
    check("R7", found_m, 1'b0);
    check("R7", found_e, 1'b0);
    check("R7", found_l, 1'b0);
    hist.delete();
    repeat (3) begin
      @(negedge clk);
      check("R7", found_m, 1'b0);
    end
    @(negedge clk);
    rst_n = 1'b1;          // release; two sync stages follow
    step(1'b0, 1'b0);      // captured while state still held in reset
  endtask

  task automatic drive_word(string bits_s, string mtag);
    for (int i = 0; i < bits_s.len(); i++) step(bits_s[i] == "1", 1'b1, mtag);
  endtask

  task automatic lfsr_run(int n);
    for (int i = 0; i < n; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[15], 1'b1);
    end
  endtask

  initial begin
    rst_n = 1'b1;
    sd = 1'b0;
    #1;
    do_reset(1'b0);
    // R4: four captured bits needed before any hit.
    drive_word("011", "R4");
    // R3: overlap and shared tails between the two patterns.
    drive_word("0110110", "R3");
    drive_word("1110110", "R3");
    drive_word("11101110", "R3");
    // R8 and R6 streams.
    drive_word("0101010101", "");
    drive_word("0010010001", "");
    lfsr_run(3000);
    // R7: reset pulled while a hit is showing.
    drive_word("0110", "R2");
    do_reset(1'b1);
    drive_word("1110", "R4");
    lfsr_run(500);
    step(1'b0, 1'b1);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule